// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block picks which physical frame to evict when a new page must be brought in. It approximates least-recently-used replacement with a rotating hand. Each frame has one referenced bit, and every access to a frame sets that frame's bit. The hand walks the frames in a circle. A frame whose bit is set gets a second chance: the hand clears the bit and moves on. The first frame found with its bit clear becomes the victim.

A victim request is a valid/ready handshake. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` then stays low for the whole sweep, so a requester holding `req_valid` high simply waits. The result is a one-cycle `res_valid` pulse that carries the chosen frame index. It has no back-pressure, so the requester must capture it in that cycle. Access reports on `touch_valid`/`touch_frame` are plain control pins and are accepted on every cycle, including during a sweep.

Top module: `clock_victim_picker`

## Requirements
- R1: After reset the hand is at frame 0, all referenced bits are clear, `req_ready` is 1 and `res_valid` is 0, so a first request with no prior accesses returns frame 0.
- R2: A cycle with `touch_valid` high sets the referenced bit of frame `touch_frame`. From the next cycle on, that frame is skipped by a sweep until its bit is cleared.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in every cycle from that edge until the cycle in which `res_valid` is 1. In that cycle `req_ready` is 1 again.
- R4: During a sweep the hand examines one frame per clock, starting at the hand position held when the request was accepted. The first examined frame whose bit is clear is the victim.
- R5: An examined frame whose bit is set has the bit cleared, and the hand moves on to the next frame.
- R6: `res_valid` is high for exactly one cycle. That cycle is the one after the examine cycle that found the victim, which is edge k+2 counted from the accept edge (edge 0), where k is the number of frames skipped. `res_frame` carries the victim index in that cycle.
- R7: After a victim is chosen the hand rests one frame past it, so the next sweep starts after the victim.
- R8: If `touch_valid` names the frame under the hand in the same cycle the hand examines it, the access wins: the frame is skipped and its bit stays set.
- R9: With no accesses during a sweep, the sweep takes at most NFRAMES+1 examine cycles.
- R10: The hand steps from frame NFRAMES-1 to frame 0, both within a sweep and after a victim at the last frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| touch_valid | input | 1 | An access to a frame happens this cycle |
| touch_frame | input | IDXW | Index of the accessed frame |
| req_valid | input | 1 | Victim request |
| req_ready | output | 1 | High while idle; the request is accepted when valid and ready are both high |
| res_valid | output | 1 | One-cycle pulse: a victim has been chosen |
| res_frame | output | IDXW | Chosen victim frame, valid with `res_valid` |

## Verification
The assertions assume that `touch_frame` always names an existing frame whenever `touch_valid` is high. The sweep-length bound only holds when no access arrives during the sweep, so the checker restarts its bound counter on any access. The bench drives only in-range frame indices. It sets referenced-bit patterns only while the block is idle, and it touches a frame during a sweep only in the dedicated same-cycle tests.

// File: rtl/clock_pick_pkg.sv
package clock_pick_pkg;
  typedef enum logic [0:0] {
    SW_IDLE = 1'b0,
    SW_SCAN = 1'b1
  } sweep_state_t;
endpackage

// File: rtl/ref_bit_array.sv
module ref_bit_array #(
  parameter int NFRAMES = 8,
  parameter int IDXW    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_valid,
  input  logic [IDXW-1:0]    touch_frame,
  input  logic               clr_en,
  input  logic [IDXW-1:0]    clr_frame,
  output logic [NFRAMES-1:0] ref_q
);
  // One referenced bit per frame. A set request beats a clear in the same cycle.
  for (genvar i = 0; i < NFRAMES; i++) begin : g_bit
    logic set_i, clr_i;
    assign set_i = touch_valid && (touch_frame == IDXW'(i));
    assign clr_i = clr_en && (clr_frame == IDXW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ref_q[i] <= 1'b0;
      else if (set_i) ref_q[i] <= 1'b1;
      else if (clr_i) ref_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/clock_hand.sv
module clock_hand #(
  parameter int NFRAMES = 8,
  parameter int IDXW    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  output logic [IDXW-1:0] hand_q
);
  localparam logic [IDXW-1:0] LAST = IDXW'(NFRAMES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hand_q <= '0;
    else if (step) begin
      if (hand_q == LAST)  hand_q <= '0;
      else                 hand_q <= hand_q + 1'b1;
    end
  end
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import clock_pick_pkg::*;
#(
  parameter int NFRAMES = 8,
  parameter int IDXW    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [IDXW-1:0]    hand_q,
  input  logic [NFRAMES-1:0] ref_q,
  input  logic               touch_valid,
  input  logic [IDXW-1:0]    touch_frame,
  output logic               step,
  output logic               clr_en,
  output logic               res_valid,
  output logic [IDXW-1:0]    res_frame
);
  sweep_state_t state_q;
  logic scanning, hit_now, cur_ref, found;

  assign scanning  = (state_q == SW_SCAN);
  // An access landing on the examined frame this cycle counts as a reference.
  assign hit_now   = touch_valid && (touch_frame == hand_q);
  assign cur_ref   = ref_q[hand_q] | hit_now;
  assign found     = scanning && !cur_ref;
  assign step      = scanning;
  assign clr_en    = scanning && cur_ref;
  assign req_ready = (state_q == SW_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SW_IDLE;
      res_valid <= 1'b0;
      res_frame <= '0;
    end else begin
      res_valid <= found;
      if (found) res_frame <= hand_q;
      case (state_q)
        SW_IDLE: if (req_valid) state_q <= SW_SCAN;
        SW_SCAN: if (!cur_ref)  state_q <= SW_IDLE;
        default:                state_q <= SW_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clock_victim_picker.sv
module clock_victim_picker #(
  parameter int NFRAMES = 8,
  localparam int IDXW   = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            touch_valid,
  input  logic [IDXW-1:0] touch_frame,
  input  logic            req_valid,
  output logic            req_ready,
  output logic            res_valid,
  output logic [IDXW-1:0] res_frame
);
  logic [NFRAMES-1:0] ref_q;
  logic [IDXW-1:0]    hand_q;
  logic               step, clr_en;

  ref_bit_array #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_refs (
    .clk(clk), .rst_n(rst_n),
    .touch_valid(touch_valid), .touch_frame(touch_frame),
    .clr_en(clr_en), .clr_frame(hand_q),
    .ref_q(ref_q)
  );

  clock_hand #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_hand (
    .clk(clk), .rst_n(rst_n), .step(step), .hand_q(hand_q)
  );

  sweep_ctrl #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .hand_q(hand_q), .ref_q(ref_q),
    .touch_valid(touch_valid), .touch_frame(touch_frame),
    .step(step), .clr_en(clr_en),
    .res_valid(res_valid), .res_frame(res_frame)
  );
endmodule

// File: rtl/clock_victim_picker_chk.sv
module clock_victim_picker_chk #(
  parameter int NFRAMES = 8,
  parameter int IDXW    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               touch_valid,
  input logic [IDXW-1:0]    touch_frame,
  input logic               req_valid,
  input logic               req_ready,
  input logic               res_valid,
  input logic [IDXW-1:0]    res_frame,
  input logic [IDXW-1:0]    hand_q,
  input logic [NFRAMES-1:0] ref_q
);
  localparam int CW = $clog2(NFRAMES + 3);
  localparam logic [IDXW-1:0] LAST = IDXW'(NFRAMES - 1);

  logic [CW-1:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       busy_cnt <= '0;
    else if (req_ready || touch_valid) busy_cnt <= '0;
    else if (busy_cnt != '1)          busy_cnt <= busy_cnt + 1'b1;
  end

  // R2
  touch_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_valid |=> ref_q[$past(touch_frame)]);

  // R3
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R4
  victim_unref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !ref_q[res_frame]);

  // R6
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R3
  ready_with_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> req_ready);

  // R7
  hand_past_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (hand_q == ((res_frame == LAST) ? '0 : res_frame + 1'b1)));

  // R9
  sweep_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CW'(NFRAMES + 1));
endmodule

bind clock_victim_picker clock_victim_picker_chk #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .touch_valid(touch_valid), .touch_frame(touch_frame),
  .req_valid(req_valid), .req_ready(req_ready),
  .res_valid(res_valid), .res_frame(res_frame),
  .hand_q(hand_q), .ref_q(ref_q)
);

// File: tb/clock_victim_picker_bench.sv
module clock_victim_picker_bench;
  localparam int N = 8;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic touch_valid = 1'b0;
  logic [W-1:0] touch_frame = '0;
  logic req_valid = 1'b0;
  logic req_ready, res_valid;
  logic [W-1:0] res_frame;

  int checks = 0;
  int fails = 0;
  bit mref [N];
  int mhand = 0;

  always #2 clk = ~clk;

  clock_victim_picker #(.NFRAMES(N)) u_clock_victim_picker (
    .clk(clk), .rst_n(rst_n),
    .touch_valid(touch_valid), .touch_frame(touch_frame),
    .req_valid(req_valid), .req_ready(req_ready),
    .res_valid(res_valid), .res_frame(res_frame)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Set referenced bits while idle, one access per cycle.
  task automatic touch_pattern(input int pat);
    for (int i = 0; i < N; i++) begin
      if (pat[i]) begin
        @(negedge clk);
        touch_valid = 1'b1;
        touch_frame = W'(i);
        mref[i] = 1'b1;
      end
    end
    @(negedge clk);
    touch_valid = 1'b0;
  endtask

  // One sweep; optionally touch the frame under the hand in the first examine cycle.
  task automatic run_sweep(input bit hit_hand);
    int k, f, victim, n, start;
    bit eff;
    start = mhand;
    k = 0;
    forever begin
      f = (start + k) % N;
      eff = mref[f] | (hit_hand && k == 0);
      if (!eff) break;
      if (hit_hand && k == 0) mref[f] = 1'b1;
      else                    mref[f] = 1'b0;
      k++;
    end
    victim = f;
    mhand = (f + 1) % N;

    @(negedge clk);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (hit_hand) begin
      touch_valid = 1'b1;
      touch_frame = W'(start);
    end
    n = 1;
    chk(req_ready == 1'b0, "R3 ready low during sweep", int'(req_ready), 0);
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      touch_valid = 1'b0;
      if (res_valid || n > 3 * N) break;
      chk(req_ready == 1'b0, "R3 ready low during sweep", int'(req_ready), 0);
    end
    chk(res_valid == 1'b1, "R6 result pulse present", int'(res_valid), 1);
    if (hit_hand)
      chk(int'(res_frame) == victim, "R8 same-cycle access skips frame", int'(res_frame), victim);
    else if (victim < start)
      chk(int'(res_frame) == victim, "R10 wrap victim", int'(res_frame), victim);
    else
      chk(int'(res_frame) == victim, "R4/R5/R7 victim", int'(res_frame), victim);
    chk(n == k + 2, "R6/R9 result latency", n, k + 2);
    chk(k <= N, "R9 sweep length", k, N);
    chk(req_ready == 1'b1, "R3 ready back with result", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    chk(res_valid == 1'b0, "R6 single-cycle pulse", int'(res_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(res_valid == 1'b0, "R1 no result after reset", int'(res_valid), 0);
    // R1: first sweep from a clean reset returns frame 0
    run_sweep(1'b0);
    // R2/R4/R5/R10: every referenced-bit pattern, hand position carried over
    for (int p = 0; p < (1 << N); p++) begin
      touch_pattern(p);
      run_sweep(1'b0);
    end
    // R9: all bits set forces a full lap
    touch_pattern((1 << N) - 1);
    run_sweep(1'b0);
    // R8: access to the examined frame in the same cycle, at every hand position
    for (int h = 0; h < N; h++) begin
      run_sweep(1'b1);
      run_sweep(1'b0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule